// File: doc/BRIEF.md
# Triggered Comparator Threshold Ramp Generator

This block drives the 7-bit reference code of an analog comparator's threshold DAC. It waits idle until one of four PWM trigger pulses arrives, provided that trigger is enabled. It then loads a start threshold chosen from one of ten sources. The sources are three filter-derived values and seven fixed comparator thresholds. From that start it walks the threshold downward by a programmable fixed-point step. The step has a 4-bit integer part and a 14-bit fraction, counted in DAC LSBs of roughly 19.5 mV each. One step is taken every N+1 module-clock cycles.

The ramp state is kept with fourteen fractional bits, so a step of less than one LSB still produces a slow, even slope on the integer output. When the state reaches zero the ramp stops there. The block then lowers its active flag and raises a done flag, which stays up until the next start. A fresh trigger edge during a ramp restarts it. Clearing the global enable freezes the output on the spot.

The configuration fields arrive as plain inputs from a register held elsewhere. Each filter value is supplied already cut down to bits 17 down to 11 of its filter word.

Top module: `cmp_ramp_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `thr_o`, `active_o` and `done_o` are all zero.
- R2: The start value is picked by `cfg_start_sel`:
  - codes 0..2 select filter value k, which is `filt_val_i[7k+6:7k]`;
  - codes 3..9 select threshold value j = code-3, which is `thr_val_i[7j+6:7j]`;
  - codes 10..15 select zero.
- R3: A start event is a 0-to-1 transition of the OR of `pwm_trig_i & cfg_trig_en`, and it counts only while `cfg_ramp_en` is 1.
  - Triggers whose enable bit is 0 have no effect.
  - A trigger held high starts the ramp only once.
- R4: One cycle after a start event:
  - `thr_o` equals the selected start value;
  - `active_o` is 1 and `done_o` is 0;
  - the fractional state and the step counter are cleared.
- R5: With `cfg_step_clks` = N, the first step lands N+1 cycles after the start and later steps are N+1 cycles apart.
- R6: Each step subtracts `cfg_step` from a 21-bit state. The state has 7 integer bits above 14 fractional bits, and `cfg_step[17:14]` is the integer part of the step. `thr_o` is the integer part of the state.
- R7: When a step would take the state to zero or below:
  - the state becomes exactly zero;
  - `active_o` falls and `done_o` rises;
  - `done_o` holds until the next start event.
- R8: A start event during a running ramp reloads the start value and restarts the step spacing.
- R9: While `cfg_ramp_en` is 0:
  - `active_o` is forced to 0;
  - `thr_o` and `done_o` hold their values;
  - no trigger starts a ramp;
  - setting the enable again does not resume a ramp that was stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ramp_en | input | 1 | Global ramp enable |
| cfg_trig_en | input | 4 | Per-trigger enables, bit k for `pwm_trig_i[k]` |
| cfg_start_sel | input | 4 | Start value source code |
| cfg_step | input | 18 | Unsigned step, 4 integer and 14 fractional bits |
| cfg_step_clks | input | 5 | Cycles per step minus one |
| filt_val_i | input | 21 | Three 7-bit filter-derived values, packed |
| thr_val_i | input | 49 | Seven 7-bit comparator thresholds, packed |
| pwm_trig_i | input | 4 | PWM trigger pulses |
| thr_o | output | 7 | Threshold code to the DAC |
| active_o | output | 1 | Ramp running |
| done_o | output | 1 | Ramp reached zero |

## Verification
The hardest case is a trigger edge that gets lost because another enabled trigger is already high. The rising edge is taken on the OR of all sources, so the second source must not restart the ramp. The stimulus reaches this by holding one enabled source high across a running ramp and then pulsing a second enabled source. The reference model must then show the ramp continuing untouched.

Saturation with a step larger than the remaining state is forced with a near-maximum step. Disabling in the middle of a ramp is followed by a trigger and then by re-enabling. A long stretch of random configuration and trigger traffic is checked against the model on every cycle.

// File: rtl/cmp_ramp_pkg.sv
package cmp_ramp_pkg;
    typedef enum logic [0:0] {
        RAMP_IDLE = 1'b0,
        RAMP_RUN  = 1'b1
    } ramp_phase_e;
endpackage

// File: rtl/cr_start_mux.sv
module cr_start_mux #(
    parameter int THR_W  = 7,
    parameter int SEL_W  = 4,
    parameter int N_FILT = 3,
    parameter int N_THR  = 7
) (
    input  logic [SEL_W-1:0]        sel_i,
    input  logic [N_FILT*THR_W-1:0] filt_i,
    input  logic [N_THR*THR_W-1:0]  thr_i,
    output logic [THR_W-1:0]        val_o
);
    // Unused codes fall through to zero.
    always_comb begin
        val_o = '0;
        for (int i = 0; i < N_FILT; i++) begin
            if (sel_i == SEL_W'(i)) val_o = filt_i[i*THR_W +: THR_W];
        end
        for (int j = 0; j < N_THR; j++) begin
            if (sel_i == SEL_W'(N_FILT + j)) val_o = thr_i[j*THR_W +: THR_W];
        end
    end
endmodule

// File: rtl/cr_trig_edge.sv
module cr_trig_edge #(
    parameter int N_TRIG = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ramp_en_i,
    input  logic [N_TRIG-1:0] trig_i,
    input  logic [N_TRIG-1:0] trig_en_i,
    output logic              start_o
);
    logic any_d, any_q;

    always_comb begin
        any_d   = |(trig_i & trig_en_i);
        start_o = ramp_en_i && any_d && !any_q;
    end

    always_ff @(posedge clk) begin
        if (rst) any_q <= 1'b0;
        else     any_q <= any_d;
    end

    AST_ONE_START_PER_EDGE: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o); // R3
endmodule

// File: rtl/cr_step_pacer.sv
module cr_step_pacer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             tick_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && !clear_i && (cnt_q == lim_i);
        cnt_d  = cnt_q;
        if (clear_i)     cnt_d = '0;
        else if (tick_o) cnt_d = '0;
        else if (run_i)  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    AST_TICK_RESTARTS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (tick_o || clear_i) |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/cmp_ramp_gen.sv
module cmp_ramp_gen
    import cmp_ramp_pkg::*;
#(
    parameter int THR_W      = 7,
    parameter int FRAC_W     = 14,
    parameter int STEP_INT_W = 4,
    parameter int CNT_W      = 5,
    parameter int SEL_W      = 4,
    parameter int N_TRIG     = 4,
    parameter int N_FILT     = 3,
    parameter int N_THR      = 7
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           cfg_ramp_en,
    input  logic [N_TRIG-1:0]              cfg_trig_en,
    input  logic [SEL_W-1:0]               cfg_start_sel,
    input  logic [STEP_INT_W+FRAC_W-1:0]   cfg_step,
    input  logic [CNT_W-1:0]               cfg_step_clks,
    input  logic [N_FILT*THR_W-1:0]        filt_val_i,
    input  logic [N_THR*THR_W-1:0]         thr_val_i,
    input  logic [N_TRIG-1:0]              pwm_trig_i,
    output logic [THR_W-1:0]               thr_o,
    output logic                           active_o,
    output logic                           done_o
);
    localparam int ACC_W = THR_W + FRAC_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        ramp_phase_e      phase;
        logic             done;
    } ramp_st_t;

    ramp_st_t         st_d, st_q;
    logic             start_ev, step_tick, pace_run;
    logic [THR_W-1:0] start_val;
    logic [ACC_W-1:0] step_ext, acc_dec;

    assign step_ext = ACC_W'(cfg_step);
    assign pace_run = cfg_ramp_en && (st_q.phase == RAMP_RUN);

    cr_start_mux #(
        .THR_W(THR_W), .SEL_W(SEL_W), .N_FILT(N_FILT), .N_THR(N_THR)
    ) u_mux (
        .sel_i(cfg_start_sel), .filt_i(filt_val_i), .thr_i(thr_val_i), .val_o(start_val)
    );

    cr_trig_edge #(.N_TRIG(N_TRIG)) u_edge (
        .clk(clk), .rst(rst), .ramp_en_i(cfg_ramp_en), .trig_i(pwm_trig_i),
        .trig_en_i(cfg_trig_en), .start_o(start_ev)
    );

    cr_step_pacer #(.CNT_W(CNT_W)) u_pace (
        .clk(clk), .rst(rst), .clear_i(start_ev), .run_i(pace_run),
        .lim_i(cfg_step_clks), .tick_o(step_tick)
    );

    always_comb begin
        st_d    = st_q;
        acc_dec = st_q.acc - step_ext;
        if (!cfg_ramp_en) begin
            st_d.phase = RAMP_IDLE;
        end else if (start_ev) begin
            st_d.acc   = {start_val, {FRAC_W{1'b0}}};
            st_d.phase = RAMP_RUN;
            st_d.done  = 1'b0;
        end else if (step_tick) begin
            if (st_q.acc <= step_ext) begin
                st_d.acc   = '0;
                st_d.phase = RAMP_IDLE;
                st_d.done  = 1'b1;
            end else begin
                st_d.acc = acc_dec;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign thr_o    = st_q.acc[ACC_W-1:FRAC_W];
    assign active_o = (st_q.phase == RAMP_RUN);
    assign done_o   = st_q.done;

    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
        start_ev |=> (active_o && !done_o && st_q.acc[FRAC_W-1:0] == '0)); // R4
    AST_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        (cfg_ramp_en && !start_ev && active_o) |=> (st_q.acc <= $past(st_q.acc))); // R6
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        !cfg_ramp_en |=> ($stable(st_q.acc) && !active_o && $stable(done_o))); // R9
    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> (st_q.acc == '0 && !active_o)); // R7
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(done_o && active_o)); // R7
endmodule

// File: tb/sim_cmp_ramp_gen.sv
module sim_cmp_ramp_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ramp_en = 1'b0;
    logic [3:0]  trig_en = '0;
    logic [3:0]  sel = '0;
    logic [17:0] step = '0;
    logic [4:0]  clks = '0;
    logic [20:0] filt = '0;
    logic [48:0] thrv = '0;
    logic [3:0]  trig = '0;
    logic [6:0]  thr_o;
    logic        active_o, done_o;

    int vectors = 0, errors = 0;
    string cur_req = "R1";
    bit finished = 0;

    int m_acc = 0, m_cnt = 0;
    bit m_act = 0, m_done = 0, m_prev = 0;

    always #4 clk = ~clk;

    cmp_ramp_gen u0 (
        .clk(clk), .rst(rst), .cfg_ramp_en(ramp_en), .cfg_trig_en(trig_en),
        .cfg_start_sel(sel), .cfg_step(step), .cfg_step_clks(clks),
        .filt_val_i(filt), .thr_val_i(thrv), .pwm_trig_i(trig),
        .thr_o(thr_o), .active_o(active_o), .done_o(done_o)
    );

    function automatic int start_of(input int code);
        if (code < 3)       return int'(filt[code*7 +: 7]);
        else if (code < 10) return int'(thrv[(code-3)*7 +: 7]);
        else                return 0;
    endfunction

    // Behavioural reference model.
    always @(posedge clk) begin
        bit any;
        any = |(trig & trig_en);
        if (rst) begin
            m_acc = 0; m_cnt = 0; m_act = 0; m_done = 0; m_prev = 0;
        end else begin
            if (!ramp_en) begin
                m_act = 0;
            end else if (any && !m_prev) begin
                m_acc = start_of(int'(sel)) * 16384;
                m_cnt = 0; m_act = 1; m_done = 0;
            end else if (m_act) begin
                if (m_cnt == int'(clks)) begin
                    m_cnt = 0;
                    if (m_acc <= int'(step)) begin
                        m_acc = 0; m_act = 0; m_done = 1;
                    end else begin
                        m_acc = m_acc - int'(step);
                    end
                end else begin
                    m_cnt = (m_cnt + 1) % 32;
                end
            end
            m_prev = any;
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            vectors++;
            if (thr_o !== 7'(m_acc / 16384) || active_o !== m_act || done_o !== m_done) begin
                errors++;
                $display("FAIL %s model: thr=%0d act=%0b done=%0b expected thr=%0d act=%0b done=%0b",
                         cur_req, thr_o, active_o, done_o, m_acc / 16384, m_act, m_done);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int bitn);
        trig[bitn] = 1'b1;
        cyc(1);
        trig[bitn] = 1'b0;
    endtask

    task automatic summary();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int k = 0; k < 3; k++) filt[k*7 +: 7] = 7'(10 + 17*k);
        for (int k = 0; k < 7; k++) thrv[k*7 +: 7] = 7'(50 + 9*k);
        cyc(3);
        check("R1", int'(thr_o) + int'(active_o) + int'(done_o), 0);
        rst = 1'b0;
        cyc(1);
        check("R1", int'(thr_o) + int'(active_o) + int'(done_o), 0);

        // R2: every source code, step 0 so the value holds
        cur_req = "R2";
        ramp_en = 1; trig_en = 4'b0001; step = 0; clks = 0;
        for (int c = 0; c < 16; c++) begin
            sel = 4'(c);
            trig[0] = 1; cyc(1);
            check("R2", int'(thr_o), start_of(c));
            check("R4", int'(active_o), 1);
            trig[0] = 0; cyc(2);
        end

        // R5/R6: step 1.0 every 4 cycles from 40
        cur_req = "R5";
        thrv[0 +: 7] = 7'd40; sel = 4'd3; step = 18'h04000; clks = 5'd3;
        trig[0] = 1; cyc(1); trig[0] = 0;
        check("R4", int'(thr_o), 40);
        cyc(3); check("R5", int'(thr_o), 40);
        cyc(1); check("R5", int'(thr_o), 39);
        cyc(4); check("R5", int'(thr_o), 38);

        // R6: fractional step 0.25 every cycle
        cur_req = "R6";
        step = 18'h01000; clks = 0;
        trig[0] = 1; cyc(1); trig[0] = 0;
        cyc(4); check("R6", int'(thr_o), 39);
        cyc(4); check("R6", int'(thr_o), 38);

        // R7: near-maximal step saturates
        cur_req = "R7";
        thrv[0 +: 7] = 7'd20; step = 18'h3FFFF;
        trig[0] = 1; cyc(1); trig[0] = 0;
        cyc(1); check("R6", int'(thr_o), 4);
        cyc(1); check("R7", int'(thr_o), 0);
        check("R7", int'(done_o), 1);
        check("R7", int'(active_o), 0);
        cyc(5); check("R7", int'(done_o), 1);

        // R3: disabled source ignored, held source starts once
        cur_req = "R3";
        trig_en = 4'b0110;
        pulse(0); pulse(3); cyc(1);
        check("R3", int'(active_o), 0);
        check("R3", int'(done_o), 1);
        trig[1] = 1; cyc(1);
        check("R3", int'(active_o), 1);
        cyc(4);
        check("R3", int'(active_o), 0);
        check("R3", int'(done_o), 1);

        // R8: second enabled source masked by held source, then restart
        cur_req = "R8";
        thrv[0 +: 7] = 7'd100; step = 18'h04000; clks = 5'd1;
        trig[1] = 0; cyc(1);
        trig[1] = 1; cyc(1);
        cyc(6); check("R8", int'(thr_o), 97);
        pulse(2); cyc(1);
        check("R8", int'(thr_o), 96);
        trig[1] = 0; cyc(1);
        pulse(2);
        check("R8", int'(thr_o), 100);
        cyc(2); check("R8", int'(thr_o), 99);

        // R9: disable mid ramp, trigger while off, re-enable
        cur_req = "R9";
        cyc(3);
        ramp_en = 0; cyc(1);
        check("R9", int'(active_o), 0);
        check("R9", int'(thr_o), 98);
        pulse(2); cyc(3);
        check("R9", int'(thr_o), 98);
        ramp_en = 1; cyc(4);
        check("R9", int'(active_o), 0);
        check("R9", int'(thr_o), 98);

        // R6 random traffic checked by the model every cycle
        cur_req = "R6";
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 99) < 3) begin
                sel = 4'($urandom_range(0, 15));
                step = 18'($urandom);
                if ($urandom_range(0, 3) == 0) step = 18'($urandom_range(0, 4000));
                clks = 5'($urandom_range(0, 31));
                trig_en = 4'($urandom);
                thrv = {$urandom, $urandom};
                filt = 21'($urandom);
            end
            ramp_en = ($urandom_range(0, 99) < 95);
            trig = ($urandom_range(0, 99) < 10) ? 4'($urandom) : 4'b0;
            cyc(1);
        end
        cyc(2);
        summary();
    end
endmodule